// File: doc/BRIEF.md
# Register-File Address-Decode Test Sequencer

This block runs a functional self-test on a small register file using nothing but the file's ordinary write port and read port. It targets faults in the write-address decoder. These are a write that lands in no register, a write that lands in every register, and a write that lands in a second or substitute register. A single pulse on `start` launches the run. The sequencer drives all four register-file control inputs, compares every returned word against the value it expects, and reports a verdict.

The run first loads a background value into every register. It then takes each register in turn as the target. It marks the target with a distinct value and reads the target back. It then reads every other register to confirm that the background survived, and finally restores the target to the background. Both the background and the mark values are parameters. The read port is taken to return data one cycle after the address is presented.

On the first wrong word the run stops. At that point the block holds the target index, the index that was read and the word that came back.

Top module: `regdec_tester`

## Requirements
- R1: After a start is accepted, the sequencer writes the background value (parameter ZERO_VAL, default all zeros) to register 0, 1, ... NREG-1 in ascending order, one per cycle, before any read. A file that powers up holding other contents therefore still passes.
- R2: Targets are taken in ascending order 0..NREG-1. For each target, exactly one write of the mark value (parameter ONE_VAL, default all ones) goes to that target.
- R3: After the mark write, one read is issued per cycle. The first read is the target itself and must return ONE_VAL. The reads then continue at target+1, target+2, ..., wrapping modulo NREG, and each of these must return ZERO_VAL. Each compare uses the word returned in the cycle after its address was presented.
- R4: After its NREG reads, the target is rewritten with ZERO_VAL, and then the next target is marked. A passing run therefore makes 3*NREG writes, of which NREG carry ONE_VAL.
- R5: A fault-free run raises done and pass, with fail low. This happens NREG + NREG*(NREG+2) clock edges after the edge that sampled start (88 for the defaults).
- R6: If a write to register A lands in every register, the run reports fail_target=A, fail_source=(A+1) mod NREG and fail_data=ONE_VAL.
- R7: If a write to register A lands in no register, the run reports fail_target=A, fail_source=A and fail_data=ZERO_VAL. This holds for a file whose registers start at ZERO_VAL.
- R8: If a write to A also writes register B, the report is fail_target=A, fail_source=B and fail_data=ONE_VAL. If a write to A goes to B instead, the report is fail_target=A, fail_source=A and fail_data=ZERO_VAL.
- R9: The first mismatch ends the run. done and fail rise at the edge that ends the cycle in which the bad word is returned. For a mismatch at read position k of target A, that edge is NREG + A*(NREG+2) + k + 3 edges after the start edge.
- R10: A start pulse while a run is in progress is ignored. The run length and the verdict are unchanged.
- R11: done, pass, fail and the failure fields hold their values until the next accepted start. The edge that accepts a start clears done, pass and fail.
- R12: After reset, done, pass, fail and rf_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run (sampled only when not running) |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_target | output | $clog2(NREG) | Register under test at the mismatch |
| fail_source | output | $clog2(NREG) | Register whose read mismatched |
| fail_data | output | DW | Word returned by the mismatching read |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | $clog2(NREG) | Register-file write index |
| rf_wdata | output | DW | Register-file write data |
| rf_raddr | output | $clog2(NREG) | Register-file read index |
| rf_rdata | input | DW | Register-file read data, one cycle after rf_raddr |

## Verification
An internal slip in the sequencer, such as a miscounted step, a wrong wrap of the read index or a compare paired with the wrong returned word, shows up at the ports in two ways. The verdict fields either name the wrong register pair, or done rises on an edge other than the one derived from the run formula. Each injected decode fault has a single expected triple of target, source and word, and a single expected completion edge. Because of that, a skew of even one cycle in the read alignment turns a pass into a fail, or moves the reported source.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_MARK,
    ST_PROBE,
    ST_RESTORE,
    ST_DONE
  } rdt_state_e;
endpackage

// File: rtl/rdt_walker.sv
module rdt_walker
  import rdt_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW = 8,
  parameter logic [DW-1:0] ZERO_VAL = '0,
  parameter logic [DW-1:0] ONE_VAL = '1,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mismatch,
  output logic          launch,
  output logic          end_ok,
  output logic          end_bad,
  output logic [IW-1:0] tgt,
  output logic          wr_en,
  output logic [IW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_issue,
  output logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_expect
);
  localparam logic [IW-1:0] LAST = IW'(NREG - 1);

  rdt_state_e    state_q;
  logic [IW-1:0] tgt_q;
  logic [IW-1:0] step_q;
  logic [IW:0]   sum;
  logic [IW-1:0] probe_idx;
  logic          busy;

  always_comb begin
    sum = {1'b0, tgt_q} + {1'b0, step_q};
    if (sum >= (IW+1)'(NREG)) probe_idx = IW'(sum - (IW+1)'(NREG));
    else probe_idx = sum[IW-1:0];
  end

  assign busy   = (state_q == ST_CLEAR) || (state_q == ST_MARK) ||
                  (state_q == ST_PROBE) || (state_q == ST_RESTORE);
  assign launch = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign end_bad = busy && mismatch;
  assign end_ok  = (state_q == ST_RESTORE) && (tgt_q == LAST) && !mismatch;
  assign tgt     = tgt_q;

  assign wr_en     = (state_q == ST_CLEAR) || (state_q == ST_MARK) || (state_q == ST_RESTORE);
  assign wr_addr   = (state_q == ST_CLEAR) ? step_q : tgt_q;
  assign wr_data   = (state_q == ST_MARK) ? ONE_VAL : ZERO_VAL;
  assign rd_issue  = (state_q == ST_PROBE);
  assign rd_addr   = probe_idx;
  assign rd_expect = (step_q == '0) ? ONE_VAL : ZERO_VAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state_q <= ST_CLEAR;
            step_q  <= '0;
            tgt_q   <= '0;
          end
        end
        ST_CLEAR: begin
          if (step_q == LAST) begin
            state_q <= ST_MARK;
            step_q  <= '0;
            tgt_q   <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_MARK: begin
          state_q <= ST_PROBE;
          step_q  <= '0;
        end
        ST_PROBE: begin
          if (mismatch) state_q <= ST_DONE;
          else if (step_q == LAST) state_q <= ST_RESTORE;
          else step_q <= step_q + 1'b1;
        end
        ST_RESTORE: begin
          if (mismatch || (tgt_q == LAST)) begin
            state_q <= ST_DONE;
          end else begin
            tgt_q   <= tgt_q + 1'b1;
            state_q <= ST_MARK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PROBE) && start && !mismatch |=> state_q != ST_CLEAR);

  // R4
  restore_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESTORE) && !mismatch && (tgt_q != LAST)
      |=> (state_q == ST_MARK) && (tgt_q == IW'($past(tgt_q) + 1'b1)));
endmodule

// File: rtl/rdt_compare.sv
module rdt_compare #(
  parameter int NREG = 8,
  parameter int DW = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [IW-1:0] issue_idx,
  input  logic [DW-1:0] issue_exp,
  input  logic [DW-1:0] rdata,
  output logic          mismatch,
  output logic [IW-1:0] miss_src,
  output logic [DW-1:0] miss_data
);
  logic          vld_q;
  logic [IW-1:0] src_q;
  logic [DW-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      src_q <= '0;
      exp_q <= '0;
    end else begin
      vld_q <= issue && !mismatch;
      src_q <= issue_idx;
      exp_q <= issue_exp;
    end
  end

  assign mismatch  = vld_q && (rdata != exp_q);
  assign miss_src  = src_q;
  assign miss_data = rdata;

  // R3
  cmp_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch |-> $past(issue));
endmodule

// File: rtl/rdt_verdict.sv
module rdt_verdict #(
  parameter int NREG = 8,
  parameter int DW = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          end_ok,
  input  logic          end_bad,
  input  logic [IW-1:0] tgt,
  input  logic [IW-1:0] src,
  input  logic [DW-1:0] data,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [IW-1:0] fail_target,
  output logic [IW-1:0] fail_source,
  output logic [DW-1:0] fail_data
);
  always_ff @(posedge clk) begin
    if (rst || launch) begin
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
      fail_target <= '0;
      fail_source <= '0;
      fail_data   <= '0;
    end else if (end_bad) begin
      done        <= 1'b1;
      fail        <= 1'b1;
      fail_target <= tgt;
      fail_source <= src;
      fail_data   <= data;
    end else if (end_ok) begin
      done <= 1'b1;
      pass <= 1'b1;
    end
  end

  // R5
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass ^ fail));

  // R11
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !launch |=> done && $stable(fail) && $stable(fail_source));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> !pass && !fail);
endmodule

// File: rtl/regdec_tester.sv
module regdec_tester #(
  parameter int NREG = 8,
  parameter int DW = 8,
  parameter logic [DW-1:0] ZERO_VAL = '0,
  parameter logic [DW-1:0] ONE_VAL = '1,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [IW-1:0] fail_target,
  output logic [IW-1:0] fail_source,
  output logic [DW-1:0] fail_data,
  output logic          rf_we,
  output logic [IW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [IW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata
);
  logic          launch, end_ok, end_bad, mismatch, rd_issue;
  logic [IW-1:0] tgt, miss_src;
  logic [DW-1:0] rd_expect, miss_data;

  rdt_walker #(.NREG(NREG), .DW(DW), .ZERO_VAL(ZERO_VAL), .ONE_VAL(ONE_VAL)) u_walk (
    .clk(clk), .rst(rst), .start(start), .mismatch(mismatch),
    .launch(launch), .end_ok(end_ok), .end_bad(end_bad), .tgt(tgt),
    .wr_en(rf_we), .wr_addr(rf_waddr), .wr_data(rf_wdata),
    .rd_issue(rd_issue), .rd_addr(rf_raddr), .rd_expect(rd_expect)
  );

  rdt_compare #(.NREG(NREG), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .issue(rd_issue), .issue_idx(rf_raddr),
    .issue_exp(rd_expect), .rdata(rf_rdata), .mismatch(mismatch),
    .miss_src(miss_src), .miss_data(miss_data)
  );

  rdt_verdict #(.NREG(NREG), .DW(DW)) u_verd (
    .clk(clk), .rst(rst), .launch(launch), .end_ok(end_ok), .end_bad(end_bad),
    .tgt(tgt), .src(miss_src), .data(miss_data),
    .done(done), .pass(pass), .fail(fail), .fail_target(fail_target),
    .fail_source(fail_source), .fail_data(fail_data)
  );

  // R1
  wdata_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wdata == ZERO_VAL) || (rf_wdata == ONE_VAL));

  // R12
  no_write_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rf_we);
endmodule

// File: tb/sim_regdec_tester.sv
module sim_regdec_tester;
  localparam int NREG = 8;
  localparam int DW = 8;
  localparam int IW = $clog2(NREG);
  localparam logic [DW-1:0] ZV = '0;
  localparam logic [DW-1:0] OV = '1;
  localparam int PASS_EDGES = NREG + NREG * (NREG + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, pass, fail, rf_we;
  logic [IW-1:0] fail_target, fail_source, rf_waddr, rf_raddr;
  logic [DW-1:0] fail_data, rf_wdata, rf_rdata;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  regdec_tester #(.NREG(NREG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .done(done), .pass(pass), .fail(fail),
    .fail_target(fail_target), .fail_source(fail_source), .fail_data(fail_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  // Fault-injectable register file model: 0 none, 1 all, 2 none-written,
  // 3 also-writes-B, 4 redirected-to-B
  logic [DW-1:0] mem [NREG];
  logic          preload_req = 1'b0;
  logic [DW-1:0] preload_val = '0;
  int            mode = 0;
  logic [IW-1:0] fa = '0, fb = '0;
  logic          cnt_clr = 1'b0;
  int            wr_total, wr_one;

  always @(posedge clk) begin
    if (preload_req) begin
      for (int i = 0; i < NREG; i++) mem[i] <= preload_val;
    end else if (rf_we) begin
      case (mode)
        1: if (rf_waddr == fa) begin
             for (int i = 0; i < NREG; i++) mem[i] <= rf_wdata;
           end else mem[rf_waddr] <= rf_wdata;
        2: if (rf_waddr != fa) mem[rf_waddr] <= rf_wdata;
        3: begin
             mem[rf_waddr] <= rf_wdata;
             if (rf_waddr == fa) mem[fb] <= rf_wdata;
           end
        4: if (rf_waddr == fa) mem[fb] <= rf_wdata;
           else mem[rf_waddr] <= rf_wdata;
        default: mem[rf_waddr] <= rf_wdata;
      endcase
    end
    rf_rdata <= mem[rf_raddr];
  end

  always @(posedge clk) begin
    if (cnt_clr) begin
      wr_total <= 0;
      wr_one   <= 0;
    end else if (rf_we) begin
      wr_total <= wr_total + 1;
      if (rf_wdata == OV) wr_one <= wr_one + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fail_edges(input int a, input int k);
    return NREG + a * (NREG + 2) + k + 3;
  endfunction

  // Runs one test; poke>0 pulses start at that edge count during the run.
  task automatic run(input logic [DW-1:0] pre, input int md, input int a, input int b,
                     input int poke, output int edges);
    @(negedge clk);
    mode = md; fa = IW'(a); fb = IW'(b);
    preload_val = pre; preload_req = 1'b1; cnt_clr = 1'b1;
    @(negedge clk);
    preload_req = 1'b0; cnt_clr = 1'b0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (edges < 1000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = (edges == poke);
      if (done) break;
    end
    start = 1'b0;
    if (edges >= 1000) chk(1'b0, "watchdog run", edges, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !pass && !fail && !rf_we, "R12 reset state", {done, pass, fail, rf_we}, 0);
  endtask

  task automatic t_clean_nonzero_bg;
    int e;
    run(8'h5A, 0, 0, 0, 0, e);
    chk(pass && !fail && done, "R1 pass with 5A power-up contents", {done, pass, fail}, 3'b110);
    chk(e == PASS_EDGES, "R5 run length", e, PASS_EDGES);
  endtask

  task automatic t_clean_poked;
    int e;
    run(8'h00, 0, 0, 0, 30, e);
    chk(pass && !fail, "R10 start mid-run ignored verdict", {pass, fail}, 2'b10);
    chk(e == PASS_EDGES, "R10 start mid-run ignored length", e, PASS_EDGES);
    chk(wr_one == NREG, "R2 mark writes", wr_one, NREG);
    chk(wr_total == 3 * NREG, "R4 total writes", wr_total, 3 * NREG);
  endtask

  task automatic t_hold_restart;
    repeat (10) @(negedge clk);
    chk(done && pass, "R11 verdict held", {done, pass}, 2'b11);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !pass && !fail, "R11 start clears verdict", {done, pass, fail}, 0);
    while (!done) @(negedge clk);
  endtask

  task automatic t_fault(input int md, input int a, input int b, input int k,
                         input int et, input int es, input logic [DW-1:0] ed, input string tag);
    int e;
    run(8'h00, md, a, b, 0, e);
    chk(done && fail && !pass, {tag, " verdict"}, {done, fail, pass}, 3'b110);
    chk(fail_target == IW'(et), {tag, " target"}, fail_target, et);
    chk(fail_source == IW'(es), {tag, " source"}, fail_source, es);
    chk(fail_data == ed, {tag, " data"}, fail_data, ed);
    chk(e == fail_edges(a, k), {tag, " R9 stop edge"}, e, fail_edges(a, k));
  endtask

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog global", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_clean_nonzero_bg();
    t_clean_poked();
    t_hold_restart();
    t_fault(1, 5, 0, 1, 5, 6, OV, "R6 all-written");
    t_fault(1, 7, 0, 1, 7, 0, OV, "R6 R3 all-written wrap");
    t_fault(2, 3, 0, 0, 3, 3, ZV, "R7 none-written");
    t_fault(3, 1, 4, 3, 1, 4, OV, "R8 also-written");
    t_fault(4, 2, 6, 0, 2, 2, ZV, "R8 redirected");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule